// File: doc/BRIEF.md
# String-to-Port Transfer Sequencer

This block moves a string of elements from memory to a single I/O port. A command supplies a source pointer, an element count, a direction bit, an element size, an address-size mode, a repeat flag, a lock flag and a 16-bit port number. For each element, the sequencer reads memory at the current pointer and writes the returned data to the port. It then steps the pointer by the element size, either up or down. With the repeat flag set, it works through the whole count, decrementing the count once per element. Without the flag, it moves exactly one element.

The address-size mode decides how many low pointer bits move and wrap; the bits above them are preserved. A command that is illegal is rejected before any bus activity, and the error code says why. A command is illegal if it carries a lock request, or if its address mode does not fit the long-mode bit. A fault input stops a running sequence before the next port write. Every command ends with a one-cycle done pulse and a status code.

Control is a five-state machine. S_IDLE waits for a command. On acceptance it goes to S_FINISH if the command is rejected or has a zero repeat count, and otherwise to S_RD_REQ. S_RD_REQ presents the read and moves to S_RD_WAIT when the request is taken. S_RD_WAIT moves to S_WR when the read data arrives. S_WR goes back to S_RD_REQ after a write if elements remain, and otherwise to S_FINISH. A fault in any of S_RD_REQ, S_RD_WAIT or S_WR goes straight to S_FINISH. S_FINISH returns to S_IDLE after one cycle.

Top module: `str_out_seq`

## Requirements
- R1: Size code 0 moves 1 byte, code 1 moves 2 bytes and code 2 moves 4 bytes, and the pointer steps by that byte count after each element.
- R2: With the direction bit at 0 the pointer steps upward; with it at 1 the pointer steps downward.
- R3: Every port write of a command carries the command's 16-bit port number unchanged.
- R4: Each memory read is issued at the pointer value left by the previous element, and the pointer changes only on a completed port write handshake.
- R5: Address mode code 0 steps and wraps only pointer bits 15:0, and code 1 does the same with bits 31:0. In both cases the upper bits are kept. Code 2 steps all 64 bits.
- R6: With repeat set, exactly count elements are moved, the count drops by one per element and ends at zero. With repeat clear, exactly one element is moved and the count is left unchanged.
- R7: Size code 3 (a 64-bit request) moves 4 bytes with write size code 2. The write data lanes above the element width are zero.
- R8: A lock request ends the command with error code 1. No memory read or port write is made, and the pointer and count keep their command values.
- R9: Address mode code 0 with the long-mode bit set, code 2 without it, and code 3 all end the command with error code 2 and no bus activity. A lock request takes priority and gives code 1.
- R10: A repeat command with a count of zero ends with error code 0 and no bus activity.
- R11: A fault seen before a port write completes ends the command with error code 3. The pointer and count stay at the values of the element that faulted.
- R12: After reset, and again one cycle after each done pulse, the block is idle and ready for a command. Done lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Idle, command accepted this cycle if valid |
| cmd_size | input | 2 | Element size code |
| cmd_amode | input | 2 | Address-size mode code |
| cmd_long | input | 1 | Long (64-bit) mode in effect |
| cmd_rep | input | 1 | Repeat over the count |
| cmd_lock | input | 1 | Lock requested (illegal) |
| cmd_dir | input | 1 | Pointer direction, 1 = downward |
| cmd_count | input | CNT_W | Element count for repeat |
| cmd_ptr | input | PTR_W | Start source pointer |
| cmd_port | input | PORT_W | Destination port number |
| fault | input | 1 | Permission fault, aborts the sequence |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory read request accepted |
| mem_req_addr | output | PTR_W | Read address |
| mem_req_size | output | 2 | Read size code |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | DATA_W | Read data |
| io_wr_valid | output | 1 | Port write valid |
| io_wr_ready | input | 1 | Port write accepted |
| io_wr_port | output | PORT_W | Port number |
| io_wr_data | output | DATA_W | Write data, unused lanes zero |
| io_wr_size | output | 2 | Write size code |
| done | output | 1 | One-cycle end-of-command pulse |
| err_code | output | 2 | 0 ok, 1 lock, 2 bad address mode, 3 fault |
| ptr_out | output | PTR_W | Current pointer |
| count_out | output | CNT_W | Current count |

## Verification
The bench sweeps every size code, both directions and all four legal pairings of mode and long-mode bit. Start pointers sit just below or above a 16-bit and a 32-bit boundary. A design that wrapped the wrong number of bits would corrupt the upper pointer half, and one that stepped the wrong way would read the wrong addresses. It targets the 64-bit size request, where a widening design would write eight bytes or the wrong size code. It also targets single-element mode, where a design that decremented the count would leave a changed count. The illegal-mode, lock and zero-count commands catch a design that still touches the bus. Faults at the first and third element catch a design that steps the pointer or count past the faulting element. Stalled port-ready cycles catch a design that steps before the write handshake completes.

// File: rtl/sos_pkg.sv
package sos_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_WORD  = 2'd1,
        SZ_DWORD = 2'd2,
        SZ_QWORD = 2'd3
    } sos_size_e;

    typedef enum logic [1:0] {
        AM_16   = 2'd0,
        AM_32   = 2'd1,
        AM_64   = 2'd2,
        AM_RSVD = 2'd3
    } sos_amode_e;

    typedef enum logic [1:0] {
        ST_OK      = 2'd0,
        ST_UNDEF   = 2'd1,
        ST_BADADDR = 2'd2,
        ST_FAULT   = 2'd3
    } sos_status_e;

    typedef enum logic [2:0] {
        S_IDLE    = 3'd0,
        S_RD_REQ  = 3'd1,
        S_RD_WAIT = 3'd2,
        S_WR      = 3'd3,
        S_FINISH  = 3'd4
    } sos_state_e;

endpackage

// File: rtl/sos_cmd_check.sv
module sos_cmd_check
    import sos_pkg::*;
(
    input  logic        lock_req,
    input  logic        long_mode,
    input  sos_amode_e  amode,
    input  sos_size_e   size_req,
    output sos_status_e status,
    output sos_size_e   eff_size
);
    logic amode_bad;

    always_comb begin
        unique case (amode)
            AM_16:   amode_bad = long_mode;
            AM_32:   amode_bad = 1'b0;
            AM_64:   amode_bad = !long_mode;
            default: amode_bad = 1'b1;
        endcase
        // lock rejection outranks the address-mode check
        if (lock_req)       status = ST_UNDEF;
        else if (amode_bad) status = ST_BADADDR;
        else                status = ST_OK;
        // a 64-bit operand request never widens beyond four bytes
        eff_size = (size_req == SZ_QWORD) ? SZ_DWORD : size_req;
    end
endmodule

// File: rtl/sos_ptr_step.sv
module sos_ptr_step
    import sos_pkg::*;
#(
    parameter int PTR_W = 64
) (
    input  logic [PTR_W-1:0] ptr,
    input  sos_size_e        size,
    input  logic             dir,
    input  sos_amode_e       amode,
    output logic [PTR_W-1:0] ptr_nxt
);
    localparam int LO16 = 16;
    localparam int LO32 = 32;

    logic [PTR_W-1:0] stride;
    logic [PTR_W-1:0] moved;

    always_comb begin
        stride = PTR_W'(1) << size;
        moved  = dir ? (ptr - stride) : (ptr + stride);
        unique case (amode)
            AM_16:   ptr_nxt = {ptr[PTR_W-1:LO16], moved[LO16-1:0]};
            AM_32:   ptr_nxt = {ptr[PTR_W-1:LO32], moved[LO32-1:0]};
            default: ptr_nxt = moved;
        endcase
    end
endmodule

// File: rtl/sos_lane_mask.sv
module sos_lane_mask
    import sos_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] raw,
    input  sos_size_e         size,
    output logic [DATA_W-1:0] masked
);
    localparam int LANES = DATA_W / 8;
    localparam int NB_W  = $clog2(LANES) + 2;

    logic [NB_W-1:0] nbytes;
    assign nbytes = NB_W'(1) << size;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        localparam logic [NB_W-1:0] LANE_IDX = NB_W'(g);
        assign masked[8*g +: 8] = (LANE_IDX < nbytes) ? raw[8*g +: 8] : 8'h00;
    end
endmodule

// File: rtl/str_out_seq.sv
module str_out_seq
    import sos_pkg::*;
#(
    parameter int PTR_W  = 64,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16,
    parameter int PORT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [1:0]        cmd_size,
    input  logic [1:0]        cmd_amode,
    input  logic              cmd_long,
    input  logic              cmd_rep,
    input  logic              cmd_lock,
    input  logic              cmd_dir,
    input  logic [CNT_W-1:0]  cmd_count,
    input  logic [PTR_W-1:0]  cmd_ptr,
    input  logic [PORT_W-1:0] cmd_port,
    input  logic              fault,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [PTR_W-1:0]  mem_req_addr,
    output logic [1:0]        mem_req_size,
    input  logic              mem_rsp_valid,
    input  logic [DATA_W-1:0] mem_rsp_data,
    output logic              io_wr_valid,
    input  logic              io_wr_ready,
    output logic [PORT_W-1:0] io_wr_port,
    output logic [DATA_W-1:0] io_wr_data,
    output logic [1:0]        io_wr_size,
    output logic              done,
    output logic [1:0]        err_code,
    output logic [PTR_W-1:0]  ptr_out,
    output logic [CNT_W-1:0]  count_out
);
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
    localparam logic [CNT_W-1:0] CNT_ZERO = '0;

    sos_state_e        state_q, state_d;
    logic [PTR_W-1:0]  ptr_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [PORT_W-1:0] port_q;
    sos_size_e         size_q;
    sos_amode_e        amode_q;
    logic              dir_q;
    logic              rep_q;
    logic [DATA_W-1:0] data_q;
    sos_status_e       err_q;

    sos_status_e       chk_status;
    sos_size_e         chk_size;
    logic [PTR_W-1:0]  ptr_nxt;
    logic [DATA_W-1:0] rsp_masked;
    logic              wr_fire;
    logic              last_elem;

    sos_cmd_check u_check (
        .lock_req  (cmd_lock),
        .long_mode (cmd_long),
        .amode     (sos_amode_e'(cmd_amode)),
        .size_req  (sos_size_e'(cmd_size)),
        .status    (chk_status),
        .eff_size  (chk_size)
    );

    sos_ptr_step #(.PTR_W(PTR_W)) u_step (
        .ptr     (ptr_q),
        .size    (size_q),
        .dir     (dir_q),
        .amode   (amode_q),
        .ptr_nxt (ptr_nxt)
    );

    sos_lane_mask #(.DATA_W(DATA_W)) u_mask (
        .raw    (mem_rsp_data),
        .size   (size_q),
        .masked (rsp_masked)
    );

    assign wr_fire   = (state_q == S_WR) && !fault && io_wr_ready;
    assign last_elem = !rep_q || (cnt_q == CNT_ONE);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (cmd_valid) begin
                    if (chk_status != ST_OK)                 state_d = S_FINISH;
                    else if (cmd_rep && cmd_count == CNT_ZERO) state_d = S_FINISH;
                    else                                     state_d = S_RD_REQ;
                end
            end
            S_RD_REQ: begin
                if (fault)              state_d = S_FINISH;
                else if (mem_req_ready) state_d = S_RD_WAIT;
            end
            S_RD_WAIT: begin
                if (fault)              state_d = S_FINISH;
                else if (mem_rsp_valid) state_d = S_WR;
            end
            S_WR: begin
                if (fault)            state_d = S_FINISH;
                else if (io_wr_ready) state_d = last_elem ? S_FINISH : S_RD_REQ;
            end
            S_FINISH: state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q   <= '0;
            cnt_q   <= '0;
            port_q  <= '0;
            size_q  <= SZ_BYTE;
            amode_q <= AM_64;
            dir_q   <= 1'b0;
            rep_q   <= 1'b0;
            data_q  <= '0;
            err_q   <= ST_OK;
        end else begin
            unique case (state_q)
                S_IDLE: begin
                    if (cmd_valid) begin
                        ptr_q   <= cmd_ptr;
                        cnt_q   <= cmd_count;
                        port_q  <= cmd_port;
                        size_q  <= chk_size;
                        amode_q <= sos_amode_e'(cmd_amode);
                        dir_q   <= cmd_dir;
                        rep_q   <= cmd_rep;
                        err_q   <= chk_status;
                    end
                end
                S_RD_REQ: begin
                    if (fault) err_q <= ST_FAULT;
                end
                S_RD_WAIT: begin
                    if (fault)              err_q  <= ST_FAULT;
                    else if (mem_rsp_valid) data_q <= rsp_masked;
                end
                S_WR: begin
                    if (fault) begin
                        err_q <= ST_FAULT;
                    end else if (wr_fire) begin
                        ptr_q <= ptr_nxt;
                        if (rep_q) cnt_q <= cnt_q - CNT_ONE;
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        cmd_ready     = (state_q == S_IDLE);
        mem_req_valid = (state_q == S_RD_REQ) && !fault;
        mem_req_addr  = ptr_q;
        mem_req_size  = size_q;
        io_wr_valid   = (state_q == S_WR) && !fault;
        io_wr_port    = port_q;
        io_wr_data    = data_q;
        io_wr_size    = size_q;
        done          = (state_q == S_FINISH);
        err_code      = err_q;
        ptr_out       = ptr_q;
        count_out     = cnt_q;
    end

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && cmd_ready)); // R12

    AST_PTR_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_ready && !(io_wr_valid && io_wr_ready)) |=> $stable(ptr_out)); // R4

    AST_PORT_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_ready |=> $stable(io_wr_port)); // R3

    AST_COUNT_DEC: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr_valid && io_wr_ready && rep_q) |=> (count_out == $past(count_out) - CNT_ONE)); // R6

    AST_NO_WIDE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        io_wr_valid |-> (io_wr_size != 2'd3)); // R7

    AST_LOCK_NO_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_ready && cmd_valid && cmd_lock) |=> (!mem_req_valid && done && err_code == 2'd1)); // R8

endmodule

// File: tb/str_out_seq_tb.sv
module str_out_seq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [1:0]  cmd_size = '0;
    logic [1:0]  cmd_amode = '0;
    logic        cmd_long = 1'b0;
    logic        cmd_rep = 1'b0;
    logic        cmd_lock = 1'b0;
    logic        cmd_dir = 1'b0;
    logic [15:0] cmd_count = '0;
    logic [63:0] cmd_ptr = '0;
    logic [15:0] cmd_port = '0;
    logic        fault = 1'b0;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b1;
    logic [63:0] mem_req_addr;
    logic [1:0]  mem_req_size;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        io_wr_valid;
    logic        io_wr_ready = 1'b1;
    logic [15:0] io_wr_port;
    logic [31:0] io_wr_data;
    logic [1:0]  io_wr_size;
    logic        done;
    logic [1:0]  err_code;
    logic [63:0] ptr_out;
    logic [15:0] count_out;

    str_out_seq u_dut (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_size(cmd_size),
        .cmd_amode(cmd_amode), .cmd_long(cmd_long), .cmd_rep(cmd_rep),
        .cmd_lock(cmd_lock), .cmd_dir(cmd_dir), .cmd_count(cmd_count),
        .cmd_ptr(cmd_ptr), .cmd_port(cmd_port), .fault(fault),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_req_size(mem_req_size),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .io_wr_valid(io_wr_valid), .io_wr_ready(io_wr_ready),
        .io_wr_port(io_wr_port), .io_wr_data(io_wr_data), .io_wr_size(io_wr_size),
        .done(done), .err_code(err_code), .ptr_out(ptr_out), .count_out(count_out)
    );

    always #5 clk = ~clk;

    int n_chk = 0;
    int n_err = 0;
    int n_wr = 0;
    int n_rd = 0;
    int fault_at = -1;
    bit stall_mode = 1'b0;
    bit rsp_pending = 1'b0;
    logic [63:0] pend_addr;
    logic [63:0] rd_log [16];
    logic [15:0] wp_log [16];
    logic [31:0] wd_log [16];
    logic [1:0]  ws_log [16];

    function automatic logic [31:0] mem_fn(input logic [63:0] a);
        return (a[31:0] * 32'h9E3779B1) ^ a[63:32];
    endfunction

    function automatic logic [63:0] step_ptr(input logic [63:0] p, input int nb,
                                             input int dir, input int am);
        logic [63:0] d;
        logic [31:0] lo32;
        logic [15:0] lo16;
        d = 64'(nb);
        if (am == 0) begin
            lo16 = (dir != 0) ? p[15:0] - d[15:0] : p[15:0] + d[15:0];
            return {p[63:16], lo16};
        end else if (am == 1) begin
            lo32 = (dir != 0) ? p[31:0] - d[31:0] : p[31:0] + d[31:0];
            return {p[63:32], lo32};
        end
        return (dir != 0) ? p - d : p + d;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // memory and port responder
    initial begin
        forever begin
            @(negedge clk);
            io_wr_ready = stall_mode ? ~io_wr_ready : 1'b1;
            mem_rsp_valid = 1'b0;
            if (rsp_pending) begin
                mem_rsp_valid = 1'b1;
                mem_rsp_data = mem_fn(pend_addr);
                rsp_pending = 1'b0;
            end
            fault = (fault_at >= 0) && (n_wr >= fault_at);
            #1;
            if (mem_req_valid && mem_req_ready) begin
                rsp_pending = 1'b1;
                pend_addr = mem_req_addr;
                if (n_rd < 16) rd_log[n_rd] = mem_req_addr;
                n_rd++;
            end
            if (io_wr_valid && io_wr_ready) begin
                if (n_wr < 16) begin
                    wp_log[n_wr] = io_wr_port;
                    wd_log[n_wr] = io_wr_data;
                    ws_log[n_wr] = io_wr_size;
                end
                n_wr++;
            end
        end
    end

    task automatic run(input int sz, input int dir, input int lng, input int am,
                       input int rep, input int lock, input logic [15:0] cnt,
                       input logic [63:0] p, input logic [15:0] port,
                       input int f_at, input bit stall);
        int nb;
        int n_tgt;
        int exp_n;
        int exp_err;
        int wsz;
        logic [63:0] ep;
        logic [31:0] msk;
        logic [15:0] ecnt;
        bit seen;
        nb  = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
        wsz = (sz == 0) ? 0 : (sz == 1) ? 1 : 2;
        msk = (sz == 0) ? 32'hFF : (sz == 1) ? 32'hFFFF : 32'hFFFF_FFFF;
        n_tgt = (rep != 0) ? int'(cnt) : 1;
        if (lock != 0) exp_err = 1;
        else if (am == 3 || (am == 0 && lng != 0) || (am == 2 && lng == 0)) exp_err = 2;
        else if (f_at >= 0 && f_at < n_tgt) exp_err = 3;
        else exp_err = 0;
        if (exp_err == 1 || exp_err == 2) exp_n = 0;
        else if (exp_err == 3) exp_n = f_at;
        else exp_n = n_tgt;

        @(negedge clk); #2;
        n_wr = 0; n_rd = 0; fault_at = f_at; stall_mode = stall;
        cmd_valid = 1'b1; cmd_size = 2'(sz); cmd_dir = 1'(dir); cmd_long = 1'(lng);
        cmd_amode = 2'(am); cmd_rep = 1'(rep); cmd_lock = 1'(lock);
        cmd_count = cnt; cmd_ptr = p; cmd_port = port;
        @(negedge clk); #2;
        cmd_valid = 1'b0;
        seen = 1'b0;
        for (int t = 0; t < 400; t++) begin
            if (done) begin seen = 1'b1; break; end
            @(negedge clk); #2;
        end
        chk(seen, "R12 done seen", 64'(seen), 64'd1);
        chk(err_code == 2'(exp_err), "R8 R9 R10 R11 err_code", 64'(err_code), 64'(exp_err));
        chk(n_wr == exp_n, "R6 R10 R11 write count", 64'(n_wr), 64'(exp_n));
        ep = p;
        for (int i = 0; i < exp_n && i < 16; i++) begin
            chk(rd_log[i] == ep, "R4 R5 read address", rd_log[i], ep);
            chk(wp_log[i] == port, "R3 port", 64'(wp_log[i]), 64'(port));
            chk(wd_log[i] == (mem_fn(ep) & msk), "R7 write data", 64'(wd_log[i]),
                64'(mem_fn(ep) & msk));
            chk(ws_log[i] == 2'(wsz), "R1 R7 write size", 64'(ws_log[i]), 64'(wsz));
            ep = step_ptr(ep, nb, dir, am);
        end
        chk(ptr_out == ep, "R1 R2 R5 R11 final pointer", ptr_out, ep);
        ecnt = (exp_err == 1 || exp_err == 2 || rep == 0) ? cnt : cnt - 16'(exp_n);
        chk(count_out == ecnt, "R6 R11 final count", 64'(count_out), 64'(ecnt));
        @(negedge clk); #2;
        chk(!done && cmd_ready, "R12 done one cycle", 64'({done, cmd_ready}), 64'b01);
        fault_at = -1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk); #2;
        chk(cmd_ready && !done && !mem_req_valid && !io_wr_valid, "R12 reset state",
            64'({cmd_ready, done, mem_req_valid, io_wr_valid}), 64'b1000);

        // sweep: size x direction x legal mode pairing, repeat count 3
        for (int sz = 0; sz < 4; sz++) begin
            for (int dir = 0; dir < 2; dir++) begin
                for (int cfg = 0; cfg < 4; cfg++) begin
                    int lng;
                    int am;
                    logic [63:0] p;
                    lng = (cfg >= 2) ? 1 : 0;
                    am  = (cfg == 0) ? 0 : (cfg == 3) ? 2 : 1;
                    if (dir == 0) p = (cfg == 0) ? 64'h1357_9BDF_0246_FFFE : 64'h1357_9BDF_FFFF_FFFC;
                    else          p = (cfg == 0) ? 64'h2468_ACE0_1111_0002 : 64'h2468_ACE0_0000_0002;
                    run(sz, dir, lng, am, 1, 0, 16'd3, p, 16'(16'hF000 + sz * 8 + dir * 4 + cfg),
                        -1, ((sz + dir + cfg) % 2) == 1);
                end
            end
        end

        // single element: count ignored and unchanged (R6)
        run(1, 0, 0, 1, 0, 0, 16'd7, 64'h0000_0000_0000_1000, 16'h0080, -1, 1'b0);
        run(3, 1, 1, 2, 0, 0, 16'd9, 64'h0000_0001_0000_0000, 16'hFFFF, -1, 1'b1);
        // rejected commands (R8, R9)
        run(0, 0, 0, 1, 1, 1, 16'd4, 64'h0000_0000_0000_2000, 16'h0010, -1, 1'b0);
        run(2, 0, 1, 0, 1, 0, 16'd4, 64'h0000_0000_0000_2000, 16'h0011, -1, 1'b0);
        run(2, 0, 0, 2, 1, 0, 16'd4, 64'h0000_0000_0000_2000, 16'h0012, -1, 1'b0);
        run(1, 1, 1, 3, 1, 0, 16'd4, 64'h0000_0000_0000_2000, 16'h0013, -1, 1'b0);
        run(1, 1, 1, 0, 1, 1, 16'd4, 64'h0000_0000_0000_2000, 16'h0014, -1, 1'b0);
        // zero repeat count (R10)
        run(2, 0, 0, 1, 1, 0, 16'd0, 64'h0000_0000_0000_3000, 16'h0020, -1, 1'b0);
        // faults (R11)
        run(1, 0, 1, 2, 1, 0, 16'd5, 64'h0000_0000_0000_4000, 16'h0030, 2, 1'b0);
        run(2, 1, 0, 0, 1, 0, 16'd5, 64'h0000_0000_0000_0004, 16'h0031, 0, 1'b1);
        run(0, 1, 0, 1, 0, 0, 16'd5, 64'h0000_0000_0000_0000, 16'h0032, 0, 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule